// File: doc/BRIEF.md
# Pipelined Burst SRAM with Selectable Deselect Timing

This block is a small synchronous SRAM core. Address, commands, write controls and write data are captured on the rising clock edge in an input stage. Read data leaves through an output register. A read therefore shows its word after the second edge that follows the command. A burst is started with a load command and is continued with an advance input. Each following word is produced one cycle after the previous one. The burst counter steps through the low two address bits and wraps within an aligned group of four words.

A mode input sets when the data drivers switch off after a deselect:
- In dual-cycle mode, the turn-off travels down the same two-stage path as read data.
- In single-cycle mode, the drivers switch off as soon as the deselect sits in the input stage.

Writes update only the chosen 9-bit lanes of the 36-bit word, or all lanes when the all-lane write input is raised. An output enable and a sleep input gate the drive enable without waiting for a clock. While sleep is high, new commands are dropped and the stored words are kept.

The data bus is split into a write-data input, a read-data output and a drive-enable output that stands for the tristate control.

Top module: `pburst_sram`

## Requirements
- R1: After reset, `drive_en` is 0 and `rd_data` is 0.
- R2: A read captured at clock edge k appears on `rd_data` after edge k+1. `drive_en` is then 1 when `out_en`=1, `sleep`=0 and no single-cycle-mode deselect was captured at edge k+1.
- R3: `cmd_adv` without `cmd_start` moves to the next word. Address bits [1:0] increment and wrap from 3 to 0, and the upper bits are kept. The burst 6,7,4,5 returns one word per cycle.
- R4: A cycle with neither `cmd_start` nor `cmd_adv`, while selected, repeats the access at the current address.
- R5: With `wr_lane_en`=1 and `wr_all`=0, only the lanes set in `wr_lane_sel` are written. Lane i is data bits [9i+8:9i].
- R6: `wr_all`=1 writes all four lanes, whatever the values of `wr_lane_en` and `wr_lane_sel`.
- R7: `wr_lane_en`=1 with `wr_lane_sel`=0 and `wr_all`=0 writes nothing, and the cycle acts as a read.
- R8: With `dual_desel`=1, a deselect (`cmd_start`=1, `cmd_sel`=0) captured at edge k leaves the last read word driven after edge k. `drive_en` is 0 after edge k+1.
- R9: With `dual_desel`=0, `drive_en` is 0 right after the edge that captures a deselect.
- R10: `out_en` gates `drive_en` without waiting for a clock edge.
- R11: `sleep`=1 forces `drive_en` to 0 at once. Commands sampled while sleep is high are dropped, and stored words are kept.
- R12: While deselected, `cmd_adv` and idle cycles start no access, and `drive_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_desel | input | 1 | 1: dual-cycle deselect, 0: single-cycle deselect |
| cmd_start | input | 1 | Load `cmd_addr` and select or deselect by `cmd_sel` |
| cmd_sel | input | 1 | Select value used with `cmd_start` |
| cmd_adv | input | 1 | Advance the burst address |
| cmd_addr | input | ADDR_W | Word address loaded by `cmd_start` |
| wr_lane_en | input | 1 | Lane write enable |
| wr_lane_sel | input | LANES | Per-lane write selects |
| wr_all | input | 1 | Write all lanes |
| wr_data | input | LANES*LANE_W | Write data |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep |
| rd_data | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | Data drive enable |

## Verification
The hardest case to reach is the cycle right after a deselect that ends a read burst. This is the only point where the two deselect modes give different results at the ports, and a single lost stage would look like a latency error. The bench runs the same read-then-deselect sequence in both modes and samples `drive_en` and `rd_data` just after the deselect edge and one cycle later. Sleep is raised during a suspended read, while the burst state is still selected. Commands are then presented during sleep, and the dropped write is shown by a later read of the same word.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/pburst_addr_gen.sv
module pburst_addr_gen #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              start,
    input  logic              sel,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              act_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              act_d,
    output logic [ADDR_W-1:0] addr_d
);
    logic [BURST_W-1:0] low_inc;

    assign low_inc = addr_q[BURST_W-1:0] + BURST_W'(1);

    always_comb begin
        act_d  = act_q;
        addr_d = addr_q;
        if (start) begin
            act_d  = sel;
            addr_d = addr_in;
        end else if (adv) begin
            addr_d = {addr_q[ADDR_W-1:BURST_W], low_inc};
        end
    end
endmodule

// File: rtl/pburst_wr_dec.sv
module pburst_wr_dec #(
    parameter int LANES = 4
) (
    input  logic             lane_en,
    input  logic [LANES-1:0] lane_sel,
    input  logic             all_lanes,
    output logic [LANES-1:0] mask,
    output logic             is_wr
);
    always_comb begin
        if (all_lanes) begin
            mask = '1;
        end else if (lane_en) begin
            mask = lane_sel;
        end else begin
            mask = '0;
        end
        is_wr = |mask;
    end
endmodule

// File: rtl/pburst_lane_mem.sv
module pburst_lane_mem #(
    parameter int W      = 9,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pburst_drive_ctl.sv
module pburst_drive_ctl (
    input  logic out_en,
    input  logic sleep,
    input  logic dual_desel,
    input  logic oe_q,
    input  logic desel_q,
    output logic drive_en
);
    logic early_cut;

    assign early_cut = ~dual_desel & desel_q;
    assign drive_en  = out_en & ~sleep & oe_q & ~early_cut;
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dual_desel,
    input  logic                    cmd_start,
    input  logic                    cmd_sel,
    input  logic                    cmd_adv,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic                    wr_lane_en,
    input  logic [LANES-1:0]        wr_lane_sel,
    input  logic                    wr_all,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    out_en,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    drive_en
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
        op_e               op;
        logic              desel;
        logic [LANES-1:0]  mask;
        logic [DW-1:0]     wd;
        logic              oe;
        logic [DW-1:0]     rd;
    } state_t;

    state_t st_q, st_d;

    logic              act_d;
    logic [ADDR_W-1:0] addr_d;
    logic [LANES-1:0]  mask_d;
    logic              is_wr_d;
    logic [DW-1:0]     arr_rdata;

    pburst_addr_gen #(
        .ADDR_W (ADDR_W),
        .BURST_W(BURST_W)
    ) u_addr (
        .start  (cmd_start),
        .sel    (cmd_sel),
        .adv    (cmd_adv),
        .addr_in(cmd_addr),
        .act_q  (st_q.act),
        .addr_q (st_q.addr),
        .act_d  (act_d),
        .addr_d (addr_d)
    );

    pburst_wr_dec #(
        .LANES(LANES)
    ) u_wdec (
        .lane_en  (wr_lane_en),
        .lane_sel (wr_lane_sel),
        .all_lanes(wr_all),
        .mask     (mask_d),
        .is_wr    (is_wr_d)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pburst_lane_mem #(
            .W     (LANE_W),
            .ADDR_W(ADDR_W)
        ) u_mem (
            .clk  (clk),
            .we   (st_q.mask[g]),
            .waddr(st_q.addr),
            .wdata(st_q.wd[g*LANE_W +: LANE_W]),
            .raddr(st_q.addr),
            .rdata(arr_rdata[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d.op    = OP_NONE;
            st_d.desel = 1'b0;
            st_d.mask  = '0;
        end else begin
            st_d.act   = act_d;
            st_d.addr  = addr_d;
            st_d.desel = cmd_start & ~cmd_sel;
            st_d.wd    = wr_data;
            if (!act_d) begin
                st_d.op   = OP_NONE;
                st_d.mask = '0;
            end else if (is_wr_d) begin
                st_d.op   = OP_WRITE;
                st_d.mask = mask_d;
            end else begin
                st_d.op   = OP_READ;
                st_d.mask = '0;
            end
        end
        st_d.oe = (st_q.op == OP_READ);
        if (st_q.op == OP_READ) begin
            st_d.rd = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pburst_drive_ctl u_drv (
        .out_en    (out_en),
        .sleep     (sleep),
        .dual_desel(dual_desel),
        .oe_q      (st_q.oe),
        .desel_q   (st_q.desel),
        .drive_en  (drive_en)
    );

    assign rd_data = st_q.rd;
endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dual_desel,
    input logic          cmd_start,
    input logic          cmd_sel,
    input logic          out_en,
    input logic          sleep,
    input logic [DW-1:0] rd_data,
    input logic          drive_en
);
    // R10: no drive while output enable is low
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !drive_en);

    // R11: sleep silences the bus
    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !drive_en);

    // R11: nothing captured during sleep reaches the output register
    p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep, 2) |-> $stable(rd_data));

    // R9: single-cycle mode cuts drive right after deselect capture
    p_scd_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_desel && $past(cmd_start && !cmd_sel && !sleep)) |-> !drive_en);

    // R8 / R12: two edges after a deselect with no restart, drive is off
    p_desel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_start && !cmd_sel && !sleep, 2) && !$past(cmd_start && cmd_sel))
        |-> !drive_en);
endmodule

bind pburst_sram pburst_sram_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_desel(dual_desel),
    .cmd_start (cmd_start),
    .cmd_sel   (cmd_sel),
    .out_en    (out_en),
    .sleep     (sleep),
    .rd_data   (rd_data),
    .drive_en  (drive_en)
);

// File: tb/tb_pburst_sram.sv
module tb_pburst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_desel = 1'b1;
    logic          cmd_start = 1'b0;
    logic          cmd_sel = 1'b0;
    logic          cmd_adv = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          wr_lane_en = 1'b0;
    logic [3:0]    wr_lane_sel = '0;
    logic          wr_all = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          out_en = 1'b1;
    logic          sleep = 1'b0;
    logic [DW-1:0] rd_data;
    logic          drive_en;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] ref_mem [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pburst_sram dut (
        .clk(clk), .rst_n(rst_n), .dual_desel(dual_desel),
        .cmd_start(cmd_start), .cmd_sel(cmd_sel), .cmd_adv(cmd_adv),
        .cmd_addr(cmd_addr), .wr_lane_en(wr_lane_en), .wr_lane_sel(wr_lane_sel),
        .wr_all(wr_all), .wr_data(wr_data), .out_en(out_en), .sleep(sleep),
        .rd_data(rd_data), .drive_en(drive_en)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a) * 36'h0_0731_5A9 + DW'(salt) * 36'h9_1234_567;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic sl, input logic av, input int a,
                       input logic bw, input logic [3:0] ln, input logic g,
                       input logic [DW-1:0] d);
        cmd_start = st; cmd_sel = sl; cmd_adv = av; cmd_addr = AW'(a);
        wr_lane_en = bw; wr_lane_sel = ln; wr_all = g; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();    cyc(0, 0, 0, 0, 0, 4'h0, 0, '0); endtask
    task automatic desel();  cyc(1, 0, 0, 0, 0, 4'h0, 0, '0); endtask
    task automatic rd_at(input int a); cyc(1, 1, 0, a, 0, 4'h0, 0, '0); endtask
    task automatic adv_rd(); cyc(0, 0, 1, 0, 0, 4'h0, 0, '0); endtask

    task automatic gw_at(input int a, input logic [DW-1:0] d);
        cyc(1, 1, 0, a, 0, 4'h0, 1, d);
        ref_mem[a] = d;
    endtask

    // read one word (read then deselect), dual-cycle mode
    task automatic read_word(input string req, input int a);
        rd_at(a);
        desel();
        chk(req, rd_data, ref_mem[a]);
        chk(req, DW'(drive_en), DW'(1));
        nop();
    endtask

    task automatic t_reset();
        chk("R1 drive", DW'(drive_en), DW'(0));
        chk("R1 data", rd_data, '0);
    endtask

    task automatic t_global_rw();
        gw_at(8, pat(8, 1));
        desel();
        rd_at(8);
        nop();
        chk("R2 latency data", rd_data, ref_mem[8]);
        chk("R2 drive", DW'(drive_en), DW'(1));
        desel();
        chk("R8 last word held", rd_data, ref_mem[8]);
        chk("R8 drive held", DW'(drive_en), DW'(1));
        nop();
        chk("R8 drive off", DW'(drive_en), DW'(0));
    endtask

    task automatic t_burst();
        cyc(1, 1, 0, 4, 0, 4'h0, 1, pat(4, 2)); ref_mem[4] = pat(4, 2);
        for (int i = 5; i < 8; i++) begin
            cyc(0, 0, 1, 0, 0, 4'h0, 1, pat(i, 2));
            ref_mem[i] = pat(i, 2);
        end
        desel();
        rd_at(6);
        adv_rd(); chk("R3 word0", rd_data, ref_mem[6]);
        adv_rd(); chk("R3 word1", rd_data, ref_mem[7]);
        adv_rd(); chk("R3 wrap word2", rd_data, ref_mem[4]);
        desel();  chk("R3 word3", rd_data, ref_mem[5]);
        adv_rd(); chk("R12 adv deselected", DW'(drive_en), DW'(0));
        adv_rd(); chk("R12 adv deselected 2", DW'(drive_en), DW'(0));
        nop();    chk("R12 idle deselected", DW'(drive_en), DW'(0));
    endtask

    task automatic t_suspend();
        rd_at(4);
        nop();    chk("R4 first", rd_data, ref_mem[4]);
        adv_rd(); chk("R4 repeated", rd_data, ref_mem[4]);
        desel();  chk("R4 after advance", rd_data, ref_mem[5]);
        nop();
    endtask

    task automatic t_byte_write();
        logic [DW-1:0] nd;
        gw_at(12, pat(12, 3));
        nd = pat(12, 4);
        cyc(1, 1, 0, 12, 1, 4'b0101, 0, nd);
        ref_mem[12][8:0]   = nd[8:0];
        ref_mem[12][26:18] = nd[26:18];
        desel();
        read_word("R5 lane merge", 12);
    endtask

    task automatic t_no_lane();
        cyc(1, 1, 0, 12, 1, 4'b0000, 0, pat(12, 9));
        desel();
        chk("R7 acts as read", rd_data, ref_mem[12]);
        chk("R7 drive", DW'(drive_en), DW'(1));
        nop();
        read_word("R7 unchanged", 12);
    endtask

    task automatic t_gw_override();
        cyc(1, 1, 0, 13, 0, 4'b0000, 1, pat(13, 5)); ref_mem[13] = pat(13, 5);
        cyc(1, 1, 0, 14, 1, 4'b0010, 1, pat(14, 5)); ref_mem[14] = pat(14, 5);
        desel();
        read_word("R6 no lane enable", 13);
        read_word("R6 one lane selected", 14);
    endtask

    task automatic t_scd();
        dual_desel = 1'b0;
        rd_at(8);
        nop();
        chk("R9 read drive", DW'(drive_en), DW'(1));
        chk("R9 read data", rd_data, ref_mem[8]);
        desel();
        chk("R9 immediate cut", DW'(drive_en), DW'(0));
        nop();
        dual_desel = 1'b1;
    endtask

    task automatic t_oe();
        rd_at(8);
        nop();
        chk("R10 driven", DW'(drive_en), DW'(1));
        out_en = 1'b0; #1;
        chk("R10 oe low", DW'(drive_en), DW'(0));
        out_en = 1'b1; #1;
        chk("R10 oe back", DW'(drive_en), DW'(1));
        desel();
        nop();
    endtask

    task automatic t_sleep();
        rd_at(8);
        nop();
        chk("R11 before sleep", DW'(drive_en), DW'(1));
        sleep = 1'b1; #1;
        chk("R11 sleep cut", DW'(drive_en), DW'(0));
        cyc(1, 1, 0, 8, 0, 4'h0, 1, pat(8, 7));
        cyc(1, 1, 0, 9, 0, 4'h0, 1, pat(9, 7));
        nop();
        chk("R11 data kept in sleep", rd_data, ref_mem[8]);
        sleep = 1'b0;
        desel();
        nop();
        read_word("R11 write dropped", 8);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        nop();
        t_reset();
        t_global_rw();
        t_burst();
        t_suspend();
        t_byte_write();
        t_no_lane();
        t_gw_override();
        t_scd();
        t_oe();
        t_sleep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule